// File: doc/BRIEF.md
# Recycling Integrator Charge Pulse Controller

This block closes the digital half of a recycling-integrator loop. A discriminator watches the integrating capacitor and raises its output when the capacitor is full. The controller answers with a charge pulse that pumps a fixed amount of charge back into the integrator input.

The pulse length is always a whole number of quanta. A quantum is `TICKS_PER_Q` clock cycles, for example 40 cycles at 100 MHz for 400 ns. Every pulse lasts at least `MIN_Q` quanta. At the last cycle of each quantum the block looks at the discriminator again and adds one more quantum while it still reads high. With a small input current the pulse is therefore three quanta long. A large input current stretches it, so the returned charge follows the current in quantum-sized steps.

The discriminator level is resynchronised inside the block. A monitor output is the OR of that resynchronised level and the charge pulse. Its rising edge marks the discriminator transition, and its width, rounded to quanta, measures the returned charge. The quantum count of the most recent pulse is held on an output. A fault flag reports when a pulse was cut off at the `MAX_Q` saturation limit.

Top module: `rint_pump_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released with `disc_in` low, `pump_out`, `mon_out` and `sat_fault` are 0 and `last_quanta` is 0.
- R2: `disc_in` passes through a two-flop synchroniser. Number the rising clock edges from the first edge that samples `disc_in` high as edge 1. After edge 2, `mon_out` is high. After edge 3, `pump_out` is high. This holds when the block is idle and armed.
- R3: A charge pulse keeps `pump_out` high for exactly N × `TICKS_PER_Q` consecutive clock cycles, where N is its quantum count.
- R4: N is never below `MIN_Q` (3), even when `disc_in` is high for a single clock cycle.
- R5: The block extends the pulse at the end of quantum k (k ≥ `MIN_Q`) only if the synchronised level is high in the last cycle of that quantum. With edges numbered as in R2, this is `disc_in` sampled high at edge 1 + k × `TICKS_PER_Q`.
- R6: N saturates at `MAX_Q`. `sat_fault` is updated at the end of every pulse to 1 when that pulse reached `MAX_Q` quanta and to 0 otherwise.
- R7: `last_quanta` takes the value N at the clock edge on which `pump_out` falls and holds it until the next pulse ends.
- R8: Once a pulse ends, no new pulse starts until the synchronised discriminator level has been seen low.
- R9: `mon_out` equals the synchronised discriminator level ORed with `pump_out`. It therefore rises one cycle before `pump_out` and stays high until both have fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_in | input | 1 | Discriminator level, asynchronous to `clk` |
| pump_out | output | 1 | Charge pulse to the integrator discharge path |
| mon_out | output | 1 | Monitor: synchronised discriminator OR charge pulse |
| last_quanta | output | QW = $clog2(MAX_Q+1) | Quantum count of the most recently finished pulse |
| sat_fault | output | 1 | Last pulse reached the `MAX_Q` limit |

## Verification
The bench drives `disc_in` high for one contiguous stretch per trial and measures `pump_out` and `mon_out` cycle by cycle. It compares them with a quantum count that a bench function derives from the stretch length.

Directed stretches are chosen to separate specific cases:
- A single-cycle stretch separates the minimum-length rule from plain level following.
- Lengths one below and exactly at a decision edge separate correct from off-by-one sampling of the extension point.
- Very long stretches separate saturation and the fault flag from unbounded growth. Because `disc_in` stays high after the pulse ends, they also show whether the block re-triggers before it has seen the discriminator low.

Random stretches with random low gaps then mix short and long pulses back to back.

// File: rtl/rint_pump_pkg.sv
package rint_pump_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_PUMP  = 2'd1,
    ST_HOLD  = 2'd2
  } pump_state_t;

  // Decide whether another quantum follows the one that just finished.
  function automatic logic want_more(input int unsigned done_q,
                                     input logic        disc_lvl,
                                     input int unsigned min_q,
                                     input int unsigned max_q);
    if (done_q < min_q) return 1'b1;
    return disc_lvl && (done_q < max_q);
  endfunction

endpackage

// File: rtl/rint_sync2.sv
module rint_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      d_sync <= 1'b0;
    end else begin
      meta_q <= d_async;
      d_sync <= meta_q;
    end
  end
endmodule

// File: rtl/rint_quantum_timer.sv
module rint_quantum_timer #(
  parameter int TICKS_PER_Q = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic q_last
);
  localparam int TW = (TICKS_PER_Q > 1) ? $clog2(TICKS_PER_Q) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_Q - 1);

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)        tick_q <= '0;
    else if (tick_q == LAST_TICK) tick_q <= '0;
    else                       tick_q <= tick_q + 1'b1;
  end

  assign q_last = run && (tick_q == LAST_TICK);

  // R3: tick count stays inside one quantum.
  p_tick_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q <= LAST_TICK);

  // R3: counter restarts from zero whenever idle.
  p_tick_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tick_q == '0) || run);
endmodule

// File: rtl/rint_pump_seq.sv
module rint_pump_seq
  import rint_pump_pkg::*;
#(
  parameter int MIN_Q = 3,
  parameter int MAX_Q = 255,
  parameter int QW    = $clog2(MAX_Q + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disc_s,
  input  logic          q_last,
  output logic          pumping,
  output logic [QW-1:0] last_q,
  output logic          fault
);
  pump_state_t   state_q;
  logic [QW-1:0] q_cnt;

  logic start_ev, extend_ev, finish_ev;

  assign start_ev  = (state_q == ST_ARMED) && disc_s;
  assign extend_ev = (state_q == ST_PUMP) && q_last &&
                     want_more(int'(q_cnt), disc_s, MIN_Q, MAX_Q);
  assign finish_ev = (state_q == ST_PUMP) && q_last && !extend_ev;
  assign pumping   = (state_q == ST_PUMP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
      q_cnt   <= '0;
      last_q  <= '0;
      fault   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ARMED: if (start_ev) begin
          state_q <= ST_PUMP;
          q_cnt   <= QW'(1);
        end
        ST_PUMP: begin
          if (extend_ev) q_cnt <= q_cnt + 1'b1;
          if (finish_ev) begin
            last_q  <= q_cnt;
            fault   <= (q_cnt == QW'(MAX_Q));
            state_q <= disc_s ? ST_HOLD : ST_ARMED;
          end
        end
        ST_HOLD: if (!disc_s) state_q <= ST_ARMED;
        default: state_q <= ST_ARMED;
      endcase
    end
  end

  // R4: a pulse never ends before the minimum number of quanta.
  p_min_quanta_r4: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ev |-> (q_cnt >= QW'(MIN_Q)));

  // R6: quantum count never passes the limit.
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pumping |-> (q_cnt <= QW'(MAX_Q)) && (q_cnt != '0));

  // R6: fault only reports a saturated pulse.
  p_fault_means_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (last_q == QW'(MAX_Q)));

  // R8: no restart straight out of the hold state.
  p_no_retrigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |=> !pumping);

  // R2: a pulse starts only after the synchronised level was high.
  p_start_on_disc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pumping) |-> $past(disc_s));

  // R7: the result register moves only as a pulse ends.
  p_result_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_q) |-> $fell(pumping));
endmodule

// File: rtl/rint_pump_ctrl.sv
module rint_pump_ctrl #(
  parameter int TICKS_PER_Q = 40,
  parameter int MIN_Q       = 3,
  parameter int MAX_Q       = 255,
  localparam int QW         = $clog2(MAX_Q + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disc_in,
  output logic          pump_out,
  output logic          mon_out,
  output logic [QW-1:0] last_quanta,
  output logic          sat_fault
);
  logic disc_s;
  logic q_last;
  logic pumping;

  rint_sync2 u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (disc_in),
    .d_sync  (disc_s)
  );

  rint_quantum_timer #(.TICKS_PER_Q(TICKS_PER_Q)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (pumping),
    .q_last (q_last)
  );

  rint_pump_seq #(.MIN_Q(MIN_Q), .MAX_Q(MAX_Q), .QW(QW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .disc_s  (disc_s),
    .q_last  (q_last),
    .pumping (pumping),
    .last_q  (last_quanta),
    .fault   (sat_fault)
  );

  assign pump_out = pumping;
  assign mon_out  = disc_s | pumping;

  // R9: monitor covers the charge pulse.
  p_mon_covers_pump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pump_out |-> mon_out);

  // R9: monitor leads the pulse by one cycle.
  p_mon_leads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_out) |-> $past(mon_out));
endmodule

// File: tb/rint_pump_ctrl_test.sv
`timescale 1ns/1ps
module rint_pump_ctrl_test;
  localparam int T    = 4;
  localparam int MINQ = 3;
  localparam int MAXQ = 8;
  localparam int QW   = $clog2(MAXQ + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          disc_in = 1'b0;
  logic          pump_out, mon_out, sat_fault;
  logic [QW-1:0] last_quanta;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  rint_pump_ctrl #(.TICKS_PER_Q(T), .MIN_Q(MINQ), .MAX_Q(MAXQ)) uut (
    .clk(clk), .rst_n(rst_n), .disc_in(disc_in),
    .pump_out(pump_out), .mon_out(mon_out),
    .last_quanta(last_quanta), .sat_fault(sat_fault)
  );

  // Expected quantum count for a discriminator held high on edges 1..h.
  function automatic int exp_quanta(input int h);
    int n = MINQ;
    while (n < MAXQ && (1 + n * T) <= h) n++;
    return n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One trial: disc_in high for h edges, then low for the rest.
  task automatic trial(input int h, input string tag);
    int n          = exp_quanta(h);
    int win        = h + 4 + MAXQ * T + 4;
    int pump_first = -1;
    int mon_first  = -1;
    int pump_cnt   = 0;
    int mon_cnt    = 0;
    disc_in = 1'b1;
    for (int c = 1; c <= win; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (pump_out) begin
        pump_cnt++;
        if (pump_first < 0) pump_first = c;
      end
      if (mon_out) begin
        mon_cnt++;
        if (mon_first < 0) mon_first = c;
      end
      if (c == h) disc_in = 1'b0;
    end
    check({"R2 pump start ", tag}, pump_first, 3);
    check({"R9 mon start ", tag}, mon_first, 2);
    check({"R3 R5 R8 pump cycles ", tag}, pump_cnt, n * T);
    check({"R9 mon cycles ", tag}, mon_cnt, imax(h + 1, 2 + n * T) - 1);
    check({"R7 last quanta ", tag}, int'(last_quanta), n);
    check({"R6 fault ", tag}, int'(sat_fault), (n == MAXQ) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check("R1 reset pump", int'(pump_out), 0);
    check("R1 reset mon", int'(mon_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle pump", int'(pump_out), 0);
    check("R1 idle fault", int'(sat_fault), 0);
    check("R1 idle count", int'(last_quanta), 0);

    trial(1,  "R4 single cycle");
    trial(12, "R5 just before decision");
    trial(13, "R5 at decision");
    trial(17, "R5 two extensions");
    trial(28, "R5 seven quanta");
    trial(33, "R6 reaches limit");
    trial(60, "R6 R8 held past limit");
    trial(5,  "R6 fault cleared");

    for (int i = 0; i < 24; i++) begin
      int h   = 1 + int'($urandom_range(0, 45));
      int gap = 3 + int'($urandom_range(0, 5));
      trial(h, "random");
      repeat (gap) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule